// File: doc/BRIEF.md
# Outbound Address Translator with Region Viewport

This block maps CPU-side 64-bit addresses onto bus-side addresses through a small set of translation regions. Each region holds a 64-bit base, a 32-bit inclusive upper bound on the low word, a 64-bit target, a transaction-type code and an enable. A request whose address falls inside an enabled region leaves the block with the region's target plus the offset from the base. It also carries the region's type code, so that memory, I/O and configuration type 0/1 traffic share one translator. For configuration regions, software places the bus, device and function numbers in the target. The block passes them through as bits 31:24, 23:19 and 18:16 of the translated address.

The regions are not mapped side by side. Software first writes a selector word that picks the direction and a region index. Every other register access then reaches only that region. One region can therefore be rebuilt while the others keep translating. Requests are answered after exactly one clock, with a hit flag. A miss returns the address unchanged.

Top module: `out_xlate`

## Requirements
- R1: After reset every region is disabled, the selector reads 0, every region field reads 0, `rsp_valid` is 0, and any request misses.
- R2: Register word offsets are: 0 selector, 1 base low, 2 base high, 3 limit, 4 target low, 5 target high, 6 type, 7 enable. Offsets 8 to 15 read 0. The selector keeps bit 31 (1 = inbound) and bits SELW-1:0 (index). The type word keeps bits 2:0. The enable word keeps only bit 31. Other bits read 0.
- R3: A field write changes only the region named by the selector. Other regions keep their contents and keep translating.
- R4: While the selector names the inbound direction or an index of NREG or above, reads of offsets 1 to 7 return 0 and writes to them change nothing.
- R5: An address hits a region when the region is enabled, address bits 63:32 equal the base high word, and bits 31:0 lie between the base low word and the limit, both bounds included.
- R6: On a hit, `rsp_addr` is the 64-bit target plus (address minus the 64-bit base), with carry into the upper word. `rsp_type` is the region's type code (0 memory, 2 I/O, 4 config type 0, 5 config type 1).
- R7: On a miss, `rsp_hit` is 0, `rsp_type` is 0 (memory), and `rsp_addr` equals the request address.
- R8: When several enabled regions hit, the region with the lowest index supplies the result.
- R9: `rsp_valid` follows `req_valid` one clock later, and the response fields belong to the request of that cycle.
- R10: A disabled region never hits, even when its fields would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 64 | CPU-side address |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_hit | output | 1 | A region matched |
| rsp_type | output | 3 | Transaction type of the matching region, 0 on a miss |
| rsp_addr | output | 64 | Translated or passed-through address |

## Verification
The assertions assume that `req_valid` and `reg_we` stay low while reset is held. They also assume that `req_addr` is known whenever `req_valid` is high, so the pass-through check on a miss can compare against the previous request. The stimulus drives every input on the falling edge from tasks and returns both strobes to zero after each single-cycle pulse. Every enable change is made through the normal register path, so the enable vector the checker watches changes only on an accepted write.

// File: rtl/out_xlate_pkg.sv
package out_xlate_pkg;
   localparam int WORD_W = 32;
   localparam int ADDR_W = 64;
   localparam int TYPE_W = 3;
   localparam int OFS_W  = 4;
   localparam int EN_BIT = 31;
   localparam int DIR_BIT = 31;

   localparam logic [OFS_W-1:0] OFS_SEL = 4'd0;
   localparam logic [OFS_W-1:0] OFS_BLO = 4'd1;
   localparam logic [OFS_W-1:0] OFS_BHI = 4'd2;
   localparam logic [OFS_W-1:0] OFS_LIM = 4'd3;
   localparam logic [OFS_W-1:0] OFS_TLO = 4'd4;
   localparam logic [OFS_W-1:0] OFS_THI = 4'd5;
   localparam logic [OFS_W-1:0] OFS_TYP = 4'd6;
   localparam logic [OFS_W-1:0] OFS_ENA = 4'd7;

   typedef struct packed {
      logic [WORD_W-1:0] base_lo;
      logic [WORD_W-1:0] base_hi;
      logic [WORD_W-1:0] limit;
      logic [WORD_W-1:0] tgt_lo;
      logic [WORD_W-1:0] tgt_hi;
      logic [TYPE_W-1:0] typ;
      logic              en;
   } region_t;
endpackage

// File: rtl/out_xlate_regs.sv
module out_xlate_regs
   import out_xlate_pkg::*;
#(
   parameter int NREG = 4,
   parameter int SELW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [OFS_W-1:0]  reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              sel_ok,
   output region_t           regions [NREG]
);
   logic            sel_dir_q;
   logic [SELW-1:0] sel_idx_q;
   region_t         cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_dir_q <= 1'b0;
         sel_idx_q <= '0;
      end else if (reg_we && reg_addr == OFS_SEL) begin
         sel_dir_q <= reg_wdata[DIR_BIT];
         sel_idx_q <= reg_wdata[SELW-1:0];
      end
   end

   assign sel_ok = !sel_dir_q && ({1'b0, sel_idx_q} < (SELW+1)'(NREG));

   for (genvar r = 0; r < NREG; r++) begin : g_region
      logic wr_this;
      assign wr_this = reg_we && sel_ok && (sel_idx_q == SELW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regions[r] <= '0;
         end else if (wr_this) begin
            case (reg_addr)
               OFS_BLO: regions[r].base_lo <= reg_wdata;
               OFS_BHI: regions[r].base_hi <= reg_wdata;
               OFS_LIM: regions[r].limit   <= reg_wdata;
               OFS_TLO: regions[r].tgt_lo  <= reg_wdata;
               OFS_THI: regions[r].tgt_hi  <= reg_wdata;
               OFS_TYP: regions[r].typ     <= reg_wdata[TYPE_W-1:0];
               OFS_ENA: regions[r].en      <= reg_wdata[EN_BIT];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      cur = '0;
      for (int r = 0; r < NREG; r++) begin
         if (sel_ok && sel_idx_q == SELW'(r)) cur = regions[r];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_SEL: begin
            reg_rdata[DIR_BIT]    = sel_dir_q;
            reg_rdata[SELW-1:0]   = sel_idx_q;
         end
         OFS_BLO: reg_rdata = cur.base_lo;
         OFS_BHI: reg_rdata = cur.base_hi;
         OFS_LIM: reg_rdata = cur.limit;
         OFS_TLO: reg_rdata = cur.tgt_lo;
         OFS_THI: reg_rdata = cur.tgt_hi;
         OFS_TYP: reg_rdata[TYPE_W-1:0] = cur.typ;
         OFS_ENA: reg_rdata[EN_BIT] = cur.en;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/out_xlate_match.sv
module out_xlate_match
   import out_xlate_pkg::*;
(
   input  region_t           rgn,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] xaddr
);
   logic [WORD_W-1:0] lo;
   logic [WORD_W-1:0] hi;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] tgt;

   assign lo   = addr[WORD_W-1:0];
   assign hi   = addr[ADDR_W-1:WORD_W];
   assign base = {rgn.base_hi, rgn.base_lo};
   assign tgt  = {rgn.tgt_hi, rgn.tgt_lo};

   assign hit   = rgn.en && (hi == rgn.base_hi) && (lo >= rgn.base_lo) && (lo <= rgn.limit);
   assign xaddr = tgt + (addr - base);
endmodule

// File: rtl/out_xlate_pick.sv
module out_xlate_pick
   import out_xlate_pkg::*;
#(
   parameter int NREG = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [NREG-1:0]   hit_vec,
   input  logic [ADDR_W-1:0] xaddr [NREG],
   input  region_t           regions [NREG],
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [TYPE_W-1:0] rsp_type,
   output logic [ADDR_W-1:0] rsp_addr
);
   logic              any_hit;
   logic [TYPE_W-1:0] sel_type;
   logic [ADDR_W-1:0] sel_addr;

   always_comb begin
      any_hit  = 1'b0;
      sel_type = '0;
      sel_addr = req_addr;
      for (int r = NREG - 1; r >= 0; r--) begin
         if (hit_vec[r]) begin
            any_hit  = 1'b1;
            sel_type = regions[r].typ;
            sel_addr = xaddr[r];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_type  <= '0;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && any_hit;
         rsp_type  <= req_valid ? sel_type : '0;
         rsp_addr  <= req_valid ? sel_addr : '0;
      end
   end
endmodule

// File: rtl/out_xlate.sv
module out_xlate
   import out_xlate_pkg::*;
#(
   parameter int NREG = 4,
   parameter int SELW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              req_valid,
   input  logic [63:0]       req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [2:0]        rsp_type,
   output logic [63:0]       rsp_addr
);
   if (NREG < 1 || NREG > (1 << SELW)) begin : g_bad_nreg
      $error("out_xlate: NREG must lie in 1 .. 2**SELW");
   end
   if (SELW < 1 || SELW > 30) begin : g_bad_selw
      $error("out_xlate: SELW must lie in 1 .. 30");
   end

   region_t           regions [NREG];
   logic [ADDR_W-1:0] xaddr   [NREG];
   logic [NREG-1:0]   hit_vec;
   logic [NREG-1:0]   en_vec;
   logic              sel_ok;

   out_xlate_regs #(.NREG(NREG), .SELW(SELW)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sel_ok    (sel_ok),
      .regions   (regions)
   );

   for (genvar r = 0; r < NREG; r++) begin : g_match
      out_xlate_match i_match (
         .rgn   (regions[r]),
         .addr  (req_addr),
         .hit   (hit_vec[r]),
         .xaddr (xaddr[r])
      );
      assign en_vec[r] = regions[r].en;
   end

   out_xlate_pick #(.NREG(NREG)) i_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .hit_vec   (hit_vec),
      .xaddr     (xaddr),
      .regions   (regions),
      .rsp_valid (rsp_valid),
      .rsp_hit   (rsp_hit),
      .rsp_type  (rsp_type),
      .rsp_addr  (rsp_addr)
   );
endmodule

// File: rtl/out_xlate_chk.sv
module out_xlate_chk #(
   parameter int NREG = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_we,
   input logic [3:0]      reg_addr,
   input logic [31:0]     reg_rdata,
   input logic            req_valid,
   input logic [63:0]     req_addr,
   input logic            rsp_valid,
   input logic            rsp_hit,
   input logic [2:0]      rsp_type,
   input logic [63:0]     rsp_addr,
   input logic [NREG-1:0] en_vec,
   input logic            sel_ok
);
   p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_miss_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_type == 3'd0 && rsp_addr == $past(req_addr)));

   p_all_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && en_vec == '0) |=> !rsp_hit);

   p_hit_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);

   p_bad_sel_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok && reg_addr != 4'd0) |-> reg_rdata == 32'd0);

   p_bad_sel_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !sel_ok && reg_addr != 4'd0) |=> $stable(en_vec));
endmodule

bind out_xlate out_xlate_chk #(.NREG(NREG)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_type  (rsp_type),
   .rsp_addr  (rsp_addr),
   .en_vec    (en_vec),
   .sel_ok    (sel_ok)
);

// File: tb/test_out_xlate.sv
`timescale 1ns/1ps
module test_out_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [2:0]  rsp_type;
   logic [63:0] rsp_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   out_xlate i_out_xlate (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic xlate(input string req, input logic [63:0] a, input logic hit,
                        input logic [2:0] typ, input logic [63:0] exp_addr);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, 64'(rsp_valid), 64'd1);
      check({req, " hit"},   64'(rsp_hit),   64'(hit));
      check({req, " type"},  64'(rsp_type),  64'(typ));
      check({req, " addr"},  rsp_addr,       exp_addr);
   endtask

   task automatic prog(input int idx, input logic [63:0] base, input logic [31:0] lim,
                       input logic [63:0] tgt, input logic [2:0] typ);
      reg_wr(4'd0, 32'(idx));
      reg_wr(4'd1, base[31:0]);
      reg_wr(4'd2, base[63:32]);
      reg_wr(4'd3, lim);
      reg_wr(4'd4, tgt[31:0]);
      reg_wr(4'd5, tgt[63:32]);
      reg_wr(4'd6, 32'(typ));
      reg_wr(4'd7, 32'h8000_0000);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      for (int a = 0; a < 8; a++) begin
         reg_rd(4'(a), d);
         check("R1 register zero", 64'(d), 64'd0);
      end
      xlate("R1 R7 miss after reset", 64'h1_4000_0000, 1'b0, 3'd0, 64'h1_4000_0000);
   endtask

   task automatic t_fields;
      logic [31:0] d;
      reg_wr(4'd0, 32'd1);
      reg_rd(4'd0, d);       check("R2 selector", 64'(d), 64'd1);
      reg_wr(4'd6, 32'hFFFF_FFFD);
      reg_rd(4'd6, d);       check("R2 type width", 64'(d), 64'd5);
      reg_wr(4'd7, 32'hFFFF_FFFF);
      reg_rd(4'd7, d);       check("R2 enable bit only", 64'(d), 64'h8000_0000);
      reg_wr(4'd7, 32'h0);
      reg_rd(4'd9, d);       check("R2 unused offset", 64'(d), 64'd0);
      prog(1, 64'h1_4000_0000, 32'h4000_FFFF, 64'h0311_0000, 3'd4);
      reg_rd(4'd2, d);       check("R2 base high", 64'(d), 64'd1);
      reg_rd(4'd3, d);       check("R2 limit", 64'(d), 64'h4000_FFFF);
   endtask

   task automatic t_window;
      xlate("R5 R6 lower bound", 64'h1_4000_0000, 1'b1, 3'd4, 64'h0311_0000);
      xlate("R5 R6 upper bound", 64'h1_4000_FFFF, 1'b1, 3'd4, 64'h0311_FFFF);
      xlate("R5 above limit",    64'h1_4001_0000, 1'b0, 3'd0, 64'h1_4001_0000);
      xlate("R5 below base",     64'h1_3FFF_FFFF, 1'b0, 3'd0, 64'h1_3FFF_FFFF);
      xlate("R5 upper mismatch", 64'h2_4000_0010, 1'b0, 3'd0, 64'h2_4000_0010);
      @(negedge clk);
      check("R9 valid drops", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_isolate;
      logic [31:0] d;
      prog(2, 64'h0_8000_0000, 32'h8FFF_FFFF, 64'h12_F800_0000, 3'd0);
      xlate("R6 carry into upper", 64'h0_8900_0000, 1'b1, 3'd0, 64'h13_0100_0000);
      xlate("R3 region 1 still active", 64'h1_4000_0020, 1'b1, 3'd4, 64'h0311_0020);
      reg_wr(4'd0, 32'd1);
      reg_rd(4'd1, d);       check("R3 region 1 base kept", 64'(d), 64'h4000_0000);
      reg_rd(4'd4, d);       check("R3 region 1 target kept", 64'(d), 64'h0311_0000);
   endtask

   task automatic t_priority;
      prog(0, 64'h1_4000_0000, 32'h4000_00FF, 64'h0000_1000, 3'd2);
      xlate("R8 lowest index wins", 64'h1_4000_0010, 1'b1, 3'd2, 64'h0000_1010);
      xlate("R8 outside region 0",  64'h1_4000_0100, 1'b1, 3'd4, 64'h0311_0100);
      reg_wr(4'd0, 32'd0);
      reg_wr(4'd7, 32'd0);
      xlate("R10 disabled region skipped", 64'h1_4000_0010, 1'b1, 3'd4, 64'h0311_0010);
   endtask

   task automatic t_bad_select;
      logic [31:0] d;
      reg_wr(4'd0, 32'h8000_0001);
      reg_rd(4'd1, d);       check("R4 inbound read zero", 64'(d), 64'd0);
      reg_wr(4'd3, 32'h0);
      reg_wr(4'd0, 32'd5);
      reg_rd(4'd7, d);       check("R4 index range read zero", 64'(d), 64'd0);
      reg_wr(4'd7, 32'h0);
      xlate("R4 writes ignored", 64'h1_4000_FFFF, 1'b1, 3'd4, 64'h0311_FFFF);
      reg_wr(4'd0, 32'd1);
      reg_rd(4'd3, d);       check("R4 limit unchanged", 64'(d), 64'h4000_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_fields;
      t_window;
      t_isolate;
      t_priority;
      t_bad_select;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule